// File: doc/BRIEF.md
# Cascadable Interrupt Controller

This block gathers up to 32 interrupt sources into one interrupt request line and one fast interrupt line. Each source first passes through a synchroniser. It is then judged according to its own trigger setting: level or edge, high/rising or low/falling. A source that qualifies shows up in a status word. A per-source enable word decides which of the status bits may reach the outputs. A per-source fast-select word sends an enabled source to the fast line instead of the normal one.

Software reaches the configuration and status through a small word-addressed register bus. Writes take effect in one cycle, and reads return their data one cycle after the request. Latched edge events are acknowledged by writing ones to the status word. Masking a source and clearing its event are two separate operations.

The two outputs are plain levels. This lets a main instance take the request outputs of two subordinate instances on its source lines 0 and 1, and their fast outputs on lines 30 and 31. The main instance leaves those lines in their level-high reset mode.

Top module: `cascade_intc`

## Requirements
- R1: After reset, reads return 0 for enable, status, trigger and fast-select. Polarity reads all ones, so every source starts as level-sensitive, active-high. `irq_o` and `fiq_o` are 0.
- R2: `irq_o` is 1 exactly when some source has its status bit at 1, its enable bit at 1 and its fast-select bit at 0. A source whose enable bit is 0 never drives an output.
- R3: A write to the status word (offset 0x08) clears the latched event of every edge source whose data bit is 1. Data bits that are 0 leave the event unchanged.
- R4: For a source with trigger bit 0 (level), the status bit equals the synchronised input when its polarity bit is 1, and the inverted input when the polarity bit is 0. Writing a 1 to its status bit has no lasting effect while the level stays active.
- R5: For a source with trigger bit 1 (edge), the status bit is set by a rising edge of the synchronised input when polarity is 1, and by a falling edge when polarity is 0. The bit holds until it is cleared. The opposite edge does not set it.
- R6: When a status clear and a new qualifying edge land in the same cycle, the status bit stays 1.
- R7: The register offsets are: 0x00 enable, 0x04 synchronised raw input, 0x08 status, 0x0C polarity, 0x10 trigger and 0x14 fast-select. Read data appears on the clock edge that samples `rd_en_i` and holds while no read is requested. An input change shows in the raw word after two clock edges.
- R8: An enabled, active source whose fast-select bit is 1 drives `fiq_o` and not `irq_o`.
- R9: `irq_o` and `fiq_o` are level outputs that stay asserted while a qualifying source is active. Fed into another instance's level-high source lines (0/1 for request, 30/31 for fast), they raise that instance's outputs.
- R10: Writing the enable word does not alter the status, and writing the status word does not alter the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously inside the block |
| src_i | input | NSRC | Asynchronous interrupt source lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte address of the word |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| fiq_o | output | 1 | Combined fast interrupt request |

## Verification
The bench builds a main instance at NSRC=32 and a subordinate at NSRC=8, both with SYNC_STAGES=2. The full 32-bit main instance gives access to cascade lines 30 and 31 as well as 0 and 1. The narrow subordinate exercises the block at a width other than the default. A vector table covers all four trigger modes, each with a qualifying and a non-qualifying transition. Directed tests then time a status clear to land in the same cycle as a fresh edge, and walk the mask-then-clear acknowledge order. A final test drives a source on the subordinate and watches it raise the main instance's request and fast lines.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADR_ENABLE = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_RAW    = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_POLAR  = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_TRIG   = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_FAST   = 5'h14;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/intc_detect.sv
module intc_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, pend_q, pend_d;
  logic [W-1:0] qual, hit;

  // Per-source qualification and edge detection
  for (genvar g = 0; g < W; g++) begin : g_src
    always_comb begin
      qual[g] = ~(lvl_i[g] ^ pol_i[g]);
      hit[g]  = trig_i[g] & (pol_i[g] ? (lvl_i[g] & ~prev_q[g])
                                      : (~lvl_i[g] & prev_q[g]));
    end
  end

  // Next state: a new edge wins over a clear
  always_comb begin
    pend_d = trig_i & (hit | (pend_q & ~clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign status_o = (trig_i & pend_q) | (~trig_i & qual);

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (($past(hit) & ~pend_q) == '0)); // R6
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~clr_i & trig_i) != '0) |=> (($past(pend_q & ~clr_i & trig_i) & ~pend_q) == '0)); // R3
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(~trig_i)) == '0)); // R4
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      raw_i,
  input  logic [W-1:0]      status_i,
  output logic [W-1:0]      en_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      trig_o,
  output logic [W-1:0]      fast_o,
  output logic [W-1:0]      clr_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] en_q, pol_q, trig_q, fast_q, rdata_q;
  logic [W-1:0] en_d, pol_d, trig_d, fast_d, rdata_d;

  always_comb begin
    en_d   = en_q;
    pol_d  = pol_q;
    trig_d = trig_q;
    fast_d = fast_q;
    clr_o  = '0;
    if (wr_i) begin
      case (addr_i)
        ADR_ENABLE: en_d   = wdata_i;
        ADR_STATUS: clr_o  = wdata_i;
        ADR_POLAR:  pol_d  = wdata_i;
        ADR_TRIG:   trig_d = wdata_i;
        ADR_FAST:   fast_d = wdata_i;
        default:    ;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_i) begin
      case (addr_i)
        ADR_ENABLE: rdata_d = en_q;
        ADR_RAW:    rdata_d = raw_i;
        ADR_STATUS: rdata_d = status_i;
        ADR_POLAR:  rdata_d = pol_q;
        ADR_TRIG:   rdata_d = trig_q;
        ADR_FAST:   rdata_d = fast_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pol_q   <= '1;
      trig_q  <= '0;
      fast_q  <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      pol_q   <= pol_d;
      trig_q  <= trig_d;
      fast_q  <= fast_d;
      rdata_q <= rdata_d;
    end
  end

  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
  assign fast_o  = fast_q;
  assign rdata_o = rdata_q;

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o)); // R7
  AST_ENABLE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == ADR_ENABLE) |=> $stable(en_o)); // R10
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import intc_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [1:0]      rst_sq;
  logic            rst_int_n;
  logic [NSRC-1:0] lvl, status, en, pol, trig, fast, clr;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  intc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(src_i), .q_o(lvl)
  );

  intc_detect #(.W(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_int_n), .lvl_i(lvl), .trig_i(trig),
    .pol_i(pol), .clr_i(clr), .status_o(status)
  );

  intc_regs #(.W(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_i(wr_en_i), .rd_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .raw_i(lvl), .status_i(status),
    .en_o(en), .pol_o(pol), .trig_o(trig), .fast_o(fast), .clr_o(clr),
    .rdata_o(rdata_o)
  );

  assign irq_o = |(status & en & ~fast);
  assign fiq_o = |(status & en & fast);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((en & ~fast) == '0) |-> !irq_o); // R2
  AST_FIQ_NEEDS_FAST: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((en & fast) == '0) |-> !fiq_o); // R8
endmodule

// File: tb/test_cascade_intc.sv
`timescale 1ns/1ps
module test_cascade_intc;
  import intc_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [31:0] drv;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, fiq;

  logic [7:0]  sub_drv, s_wdata, s_rdata;
  logic        s_wr;
  logic [4:0]  s_addr;
  logic        sub_irq, sub_fiq;

  wire [31:0] main_src = {drv[31], sub_fiq, drv[29:1], sub_irq};

  cascade_intc #(.NSRC(32), .SYNC_STAGES(2)) i_cascade_intc (
    .clk(clk), .rst_n(rst_n), .src_i(main_src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  cascade_intc #(.NSRC(8), .SYNC_STAGES(2)) i_sub (
    .clk(clk), .rst_n(rst_n), .src_i(sub_drv), .wr_en_i(s_wr), .rd_en_i(1'b0),
    .addr_i(s_addr), .wdata_i(s_wdata), .rdata_o(s_rdata), .irq_o(sub_irq), .fiq_o(sub_fiq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] sh_en, sh_pol, sh_trig, sh_fast, d;

  // {trig, pol, before, after, expected status}
  localparam logic [4:0] VEC [8] = '{
    5'b0_1_0_1_1, 5'b0_1_1_0_0, 5'b0_0_1_0_1, 5'b0_0_0_1_0,
    5'b1_1_0_1_1, 5'b1_1_1_0_0, 5'b1_0_1_0_1, 5'b1_0_0_1_0
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic swr(input logic [4:0] a, input logic [7:0] v);
    s_wr = 1'b1; s_addr = a; s_wdata = v;
    @(negedge clk);
    s_wr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; drv = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    sub_drv = '0; s_wr = 0; s_addr = '0; s_wdata = '0;
    sh_en = '0; sh_pol = '1; sh_trig = '0; sh_fast = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    rd(ADR_ENABLE, d); chk("R1 enable", d, 32'h0);
    rd(ADR_STATUS, d); chk("R1 status", d, 32'h0);
    rd(ADR_TRIG, d);   chk("R1 trigger", d, 32'h0);
    rd(ADR_POLAR, d);  chk("R1 polarity", d, 32'hFFFF_FFFF);
    rd(ADR_FAST, d);   chk("R1 fast", d, 32'h0);
    chk("R1 irq/fiq", {30'd0, irq, fiq}, 32'h0);

    // R4/R5 vector table over the four trigger modes, sources 8..15
    for (int i = 0; i < 8; i++) begin
      int k = 8 + i;
      logic [4:0] v = VEC[i];
      drv[k] = v[2];
      tick(4);
      sh_trig[k] = v[4]; sh_pol[k] = v[3];
      wr(ADR_TRIG, sh_trig);
      wr(ADR_POLAR, sh_pol);
      tick(4);
      wr(ADR_STATUS, 32'h1 << k);
      drv[k] = v[1];
      tick(5);
      rd(ADR_STATUS, d);
      chk(v[4] ? "R5 edge mode vector" : "R4 level mode vector", {31'd0, d[k]}, {31'd0, v[0]});
    end

    // R7 raw read after two edges, and read hold
    drv[20] = 1'b1;
    tick(2);
    rd(ADR_RAW, d); chk("R7 raw input", {31'd0, d[20]}, 32'h1);
    tick(3);
    chk("R7 read data held", {31'd0, rdata[20]}, 32'h1);
    rd(ADR_STATUS, d); chk("R4 level high status", {31'd0, d[20]}, 32'h1);

    // R2 enable masking
    chk("R2 masked irq", {31'd0, irq}, 32'h0);
    sh_en[20] = 1'b1; wr(ADR_ENABLE, sh_en);
    chk("R2 enabled irq", {31'd0, irq}, 32'h1);
    rd(ADR_ENABLE, d); chk("R7 enable readback", d, sh_en);
    sh_en[20] = 1'b0; wr(ADR_ENABLE, sh_en);
    chk("R2 remasked irq", {31'd0, irq}, 32'h0);

    // R4 clearing an active level has no lasting effect
    wr(ADR_STATUS, 32'h1 << 20);
    rd(ADR_STATUS, d); chk("R4 level clear ignored", {31'd0, d[20]}, 32'h1);
    drv[20] = 1'b0;

    // R3 write-one-to-clear on an edge source
    sh_trig[21] = 1'b1; wr(ADR_TRIG, sh_trig);
    drv[21] = 1'b1; tick(4);
    rd(ADR_STATUS, d); chk("R5 rising latched", {31'd0, d[21]}, 32'h1);
    wr(ADR_STATUS, 32'h0);
    rd(ADR_STATUS, d); chk("R3 zero write keeps", {31'd0, d[21]}, 32'h1);
    wr(ADR_STATUS, 32'h1 << 21);
    rd(ADR_STATUS, d); chk("R3 one write clears", {31'd0, d[21]}, 32'h0);

    // R5 falling edge ignored in rising mode
    drv[21] = 1'b0; tick(4);
    rd(ADR_STATUS, d); chk("R5 opposite edge ignored", {31'd0, d[21]}, 32'h0);

    // R6 clear lands in the same cycle as a new edge
    drv[21] = 1'b1;
    tick(2);
    wr(ADR_STATUS, 32'h1 << 21);
    rd(ADR_STATUS, d); chk("R6 edge beats clear", {31'd0, d[21]}, 32'h1);

    // R10 mask then clear are separate
    sh_en[21] = 1'b1; wr(ADR_ENABLE, sh_en);
    chk("R2 edge pending irq", {31'd0, irq}, 32'h1);
    sh_en[21] = 1'b0; wr(ADR_ENABLE, sh_en);
    chk("R2 mask drops irq", {31'd0, irq}, 32'h0);
    rd(ADR_STATUS, d); chk("R10 mask keeps status", {31'd0, d[21]}, 32'h1);
    sh_en[21] = 1'b1; wr(ADR_ENABLE, sh_en);
    wr(ADR_STATUS, 32'h1 << 21);
    rd(ADR_ENABLE, d); chk("R10 clear keeps enable", d, sh_en);
    chk("R3 cleared irq low", {31'd0, irq}, 32'h0);

    // R8 fast select routing
    sh_fast[22] = 1'b1; wr(ADR_FAST, sh_fast);
    sh_en[22] = 1'b1; wr(ADR_ENABLE, sh_en);
    drv[22] = 1'b1; tick(3);
    chk("R8 fast source irq/fiq", {30'd0, irq, fiq}, 32'h1);
    sh_fast[22] = 1'b0; wr(ADR_FAST, sh_fast);
    chk("R8 normal source irq/fiq", {30'd0, irq, fiq}, 32'h2);
    rd(ADR_FAST, d); chk("R7 fast readback", d, sh_fast);
    drv[22] = 1'b0; tick(3);
    chk("R2 inactive source", {30'd0, irq, fiq}, 32'h0);

    // R9 cascade from subordinate into lines 0 and 30
    sh_en[0] = 1'b1; sh_en[30] = 1'b1; wr(ADR_ENABLE, sh_en);
    sh_fast[30] = 1'b1; wr(ADR_FAST, sh_fast);
    swr(ADR_FAST, 8'h20);
    swr(ADR_ENABLE, 8'h28);
    sub_drv[3] = 1'b1; tick(6);
    chk("R9 cascade request", {30'd0, irq, fiq}, 32'h2);
    sub_drv[5] = 1'b1; tick(6);
    rd(ADR_STATUS, d); chk("R9 cascade lines", {d[30], d[0]}, 2'b11);
    chk("R9 cascade both", {30'd0, irq, fiq}, 32'h3);
    sub_drv = '0; tick(6);
    chk("R9 cascade released", {30'd0, irq, fiq}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule